// File: doc/BRIEF.md
# Configurable registered buffer with parity

This block is a clocked register stage for memory address and command lines. A two-bit static mode input selects whether it registers 25 data inputs one-to-one, or registers only the low 14 inputs and drives each of them onto two output bits so that one stage can feed two destinations. One stage after the data is captured, a parity-check output is produced. It is the XOR of the captured data bits and the parity bit that arrived with them. An active-low error flag reports that check.

Two active-low chip-select inputs gate the whole stage. When both are high, the captured data and the parity result keep their values across clock edges, which saves switching power. When either one is low, the stage updates on every rising edge. Tying `cs1_n` low disables gating entirely, and `cs0_n` then has no effect on the outputs' timing beyond that of an ordinary data input.

The stage has a fixed latency and has no flow control. Data is taken whenever the chip-select gate is open, and there is no back-pressure path. An active-low reset clears everything at once, without waiting for a clock edge. It overrides the chip-select gate. Its release is synchronized to the clock through two flip-flops.

Top module: `cfg_regbuf`

## Requirements
- R1: With `cfg_mode` 2'b00 or 2'b11 (one-to-one), after an enabled rising edge `q_out[i]` equals the `d_in[i]` sampled at that edge for i = 0..24, and `q_out[27:25]` are 0.
- R2: With `cfg_mode` 2'b01 (stacked one-to-two), after an enabled edge both `q_out[i]` and `q_out[i+14]` equal the sampled `d_in[i]` for i = 0..13.
- R3: With `cfg_mode` 2'b10 (interleaved one-to-two), after an enabled edge both `q_out[2i]` and `q_out[2i+1]` equal the sampled `d_in[i]` for i = 0..13.
- R4: In both one-to-two modes, `d_in[24:14]` affect neither `q_out` nor `pchk_out`.
- R5: While `rst_n` is low, `q_out` is 0, `pchk_out` is 0 and `err_n` is 1, with no clock edge needed. The first edge that captures data is the third rising edge after `rst_n` goes high.
- R6: At a rising edge where `cs0_n` and `cs1_n` are both high, `q_out`, `pchk_out` and `err_n` keep their values.
- R7: At a rising edge where either chip select is low, the stage captures new data and a new parity result.
- R8: At an enabled edge, `pchk_out` takes the XOR of the data bits held since the previous capture and the parity bit captured with them. All 25 bits count in one-to-one mode and bits 0..13 count in one-to-two modes. `err_n` is the inverse of `pchk_out`, so it is low exactly while the check is 1.
- R9: If `d_in` and `par_in` stay low after reset release while the clock runs, all outputs stay at their reset values with no glitch.
- R10: Asserting `rst_n` low while both chip selects are high still clears the outputs at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| cfg_mode | input | 2 | Static mode: 00/11 one-to-one, 01 stacked one-to-two, 10 interleaved one-to-two |
| cs0_n | input | 1 | First active-low chip select |
| cs1_n | input | 1 | Second active-low chip select; tie low to disable gating |
| d_in | input | 25 | Data inputs |
| par_in | input | 1 | Parity bit accompanying `d_in` |
| q_out | output | 28 | Registered data, fanned out per mode |
| pchk_out | output | 1 | Registered parity-check result |
| err_n | output | 1 | Active-low parity error flag |

## Verification
A wrong capture register shows on `q_out` right after the edge that loaded it. One edge later it also shows on `pchk_out` and `err_n`, because the parity is formed from the held data. A gate that leaks, or a fan-out map that points at the wrong source bit, becomes visible as soon as the input pattern changes under idle chip selects or in a one-to-two mode. A reset synchronizer that is off by a stage shows as a capture one cycle early or late after release. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported within one or two clocks of its cause.

// File: rtl/cfg_regbuf_pkg.sv
package cfg_regbuf_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE     = 2'b00,
    MODE_STACK    = 2'b01,
    MODE_INTLV    = 2'b10,
    MODE_WIDE_ALT = 2'b11
  } mode_e;

  function automatic logic mode_is_split(mode_e m);
    return (m == MODE_STACK) || (m == MODE_INTLV);
  endfunction

endpackage

// File: rtl/cfg_regbuf_rstsync.sv
module cfg_regbuf_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync = chain[STAGES-1];

endmodule

// File: rtl/cfg_regbuf_map.sv
module cfg_regbuf_map
  import cfg_regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int OUT_W    = 28
) (
  input  mode_e              mode,
  input  logic [WIDE_W-1:0]  data,
  output logic [OUT_W-1:0]   q
);

  for (genvar j = 0; j < OUT_W; j++) begin : g_bit
    logic wide_bit, stack_bit, intlv_bit;

    if (j < WIDE_W) begin : g_wide
      assign wide_bit = data[j];
    end else begin : g_wide_pad
      assign wide_bit = 1'b0;
    end

    if (j < 2 * NARROW_W) begin : g_split
      assign stack_bit = data[j % NARROW_W];
      assign intlv_bit = data[j / 2];
    end else begin : g_split_pad
      assign stack_bit = 1'b0;
      assign intlv_bit = 1'b0;
    end

    assign q[j] = (mode == MODE_STACK) ? stack_bit :
                  (mode == MODE_INTLV) ? intlv_bit : wide_bit;
  end

endmodule

// File: rtl/cfg_regbuf_parity.sv
module cfg_regbuf_parity #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_sync,
  input  logic         en,
  input  logic [W-1:0] data,
  input  logic         par,
  output logic         pchk
);

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)  pchk <= 1'b0;
    else if (en)    pchk <= (^data) ^ par;
  end

endmodule

// File: rtl/cfg_regbuf.sv
module cfg_regbuf
  import cfg_regbuf_pkg::*;
#(
  parameter int WIDE_W      = 25,
  parameter int NARROW_W    = 14,
  parameter int SYNC_STAGES = 2,
  localparam int OUT_W = (2 * NARROW_W > WIDE_W) ? 2 * NARROW_W : WIDE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cs0_n,
  input  logic              cs1_n,
  input  logic [WIDE_W-1:0] d_in,
  input  logic              par_in,
  output logic [OUT_W-1:0]  q_out,
  output logic              pchk_out,
  output logic              err_n
);

  mode_e             mode;
  logic              split;
  logic              rst_int;
  logic              en;
  logic [WIDE_W-1:0] masked;
  logic [WIDE_W-1:0] dcap;
  logic              par_q;

  assign mode  = mode_e'(cfg_mode);
  assign split = mode_is_split(mode);
  assign en    = !(cs0_n && cs1_n);

  cfg_regbuf_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_sync (rst_int)
  );

  // Upper inputs are cut off in the one-to-two modes.
  for (genvar i = 0; i < WIDE_W; i++) begin : g_mask
    if (i < NARROW_W) begin : g_keep
      assign masked[i] = d_in[i];
    end else begin : g_gate
      assign masked[i] = d_in[i] & ~split;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      dcap  <= '0;
      par_q <= 1'b0;
    end else if (en) begin
      dcap  <= masked;
      par_q <= par_in;
    end
  end

  cfg_regbuf_map #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)) u_map (
    .mode (mode),
    .data (dcap),
    .q    (q_out)
  );

  cfg_regbuf_parity #(.W(WIDE_W)) u_parity (
    .clk      (clk),
    .rst_sync (rst_int),
    .en       (en),
    .data     (dcap),
    .par      (par_q),
    .pchk     (pchk_out)
  );

  assign err_n = ~pchk_out;

  // R5
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      reset_clear_chk: assert (q_out == '0 && pchk_out == 1'b0 && err_n == 1'b1);
    end
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (cs0_n && cs1_n) |=> ($stable(q_out) && $stable(pchk_out) && $stable(err_n)));

  // R7
  capture_when_sel_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (!cs0_n || !cs1_n) |=> (dcap == $past(masked)));

  // R4
  split_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_int)
    split |-> (dcap[WIDE_W-1:NARROW_W] == '0));

  // R2
  stack_dup_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (mode == MODE_STACK) |-> (q_out[NARROW_W-1:0] == q_out[2*NARROW_W-1:NARROW_W]));

  for (genvar k = 0; k < NARROW_W; k++) begin : g_intlv_chk
    // R3
    intlv_pair_chk: assert property (@(posedge clk) disable iff (!rst_int)
      (mode == MODE_INTLV) |-> (q_out[2*k] == q_out[2*k+1]));
  end

endmodule

// File: tb/cfg_regbuf_test.sv
module cfg_regbuf_test;

  localparam int WW = 25;
  localparam int NW = 14;
  localparam int OW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [1:0]    cfg_mode = 2'b00;
  logic          cs0_n = 1'b0;
  logic          cs1_n = 1'b1;
  logic [WW-1:0] d_in = '0;
  logic          par_in = 1'b0;
  logic [OW-1:0] q_out;
  logic          pchk_out;
  logic          err_n;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R5";

  logic [WW-1:0] m_dcap = '0;
  logic          m_par = 1'b0;
  logic          m_pchk = 1'b0;
  int            sync_cnt = 0;

  cfg_regbuf uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .d_in(d_in), .par_in(par_in), .q_out(q_out), .pchk_out(pchk_out), .err_n(err_n)
  );

  always #4 clk = ~clk;

  function automatic logic [OW-1:0] expect_q(logic [1:0] m, logic [WW-1:0] c);
    logic [OW-1:0] e;
    for (int j = 0; j < OW; j++) begin
      case (m)
        2'b01:   e[j] = c[j % NW];
        2'b10:   e[j] = c[j / 2];
        default: e[j] = (j < WW) ? c[j] : 1'b0;
      endcase
    end
    return e;
  endfunction

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_dcap = '0; m_par = 1'b0; m_pchk = 1'b0; sync_cnt = 0;
    end else begin
      if (sync_cnt >= 2 && (!cs0_n || !cs1_n)) begin
        logic [WW-1:0] cap;
        cap = d_in;
        if (cfg_mode == 2'b01 || cfg_mode == 2'b10) cap = d_in & WW'((1 << NW) - 1);
        m_pchk = (^m_dcap) ^ m_par;
        m_dcap = cap;
        m_par  = par_in;
      end
      if (sync_cnt < 2) sync_cnt++;
    end
  end

  always @(negedge rst_n) begin
    m_dcap = '0; m_par = 1'b0; m_pchk = 1'b0; sync_cnt = 0;
  end

  task automatic compare(string tag);
    logic [OW-1:0] eq;
    eq = expect_q(cfg_mode, m_dcap);
    checks++;
    if (q_out !== eq || pchk_out !== m_pchk || err_n !== ~m_pchk) begin
      errors++;
      $display("FAIL %s: q=%h pchk=%b err_n=%b expected q=%h pchk=%b err_n=%b",
               tag, q_out, pchk_out, err_n, eq, m_pchk, ~m_pchk);
    end
  endtask

  always @(negedge clk) if (!done && $time > 2) compare(cur_req);

  task automatic step(logic c0, logic c1, logic [WW-1:0] d, logic p);
    @(negedge clk); #1;
    cs0_n = c0; cs1_n = c1; d_in = d; par_in = p;
  endtask

  task automatic rand_steps(int n, logic c0, logic c1);
    for (int i = 0; i < n; i++) step(c0, c1, WW'($urandom), 1'($urandom));
  endtask

  task automatic enter_reset(string tag, logic [1:0] new_mode);
    @(negedge clk); #1;
    rst_n = 1'b0;
    #1;
    compare(tag);
    cfg_mode = new_mode;
    d_in = '0; par_in = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b1, '0, 1'b0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #1 compare("R5");
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R9/R5";
    repeat (4) step(1'b0, 1'b1, '0, 1'b0);

    cur_req = "R1/R7/R8";
    step(1'b0, 1'b1, 25'h0000001, 1'b0);
    step(1'b0, 1'b1, 25'h1FFFFFF, 1'b1);
    rand_steps(20, 1'b0, 1'b1);

    cur_req = "R6";
    rand_steps(10, 1'b1, 1'b1);

    cur_req = "R7";
    rand_steps(10, 1'b1, 1'b0);

    cur_req = "R10";
    cs0_n = 1'b1; cs1_n = 1'b1;
    enter_reset("R10", 2'b01);

    cur_req = "R2/R4/R8";
    rand_steps(20, 1'b0, 1'b1);
    cur_req = "R4";
    repeat (3) step(1'b0, 1'b0, 25'h1FFC000, 1'b0);

    cur_req = "R5";
    enter_reset("R5", 2'b10);
    cur_req = "R3/R4/R8";
    rand_steps(20, 1'b1, 1'b0);
    cur_req = "R4";
    repeat (3) step(1'b0, 1'b1, 25'h1FFC000, 1'b1);

    cur_req = "R5";
    enter_reset("R5", 2'b11);
    cur_req = "R1/R8";
    rand_steps(15, 1'b0, 1'b1);

    cur_req = "R6/R7";
    for (int i = 0; i < 40; i++) step(1'($urandom), 1'($urandom), WW'($urandom), 1'($urandom));

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule